// File: doc/BRIEF.md
# Four-Word Latch Memory with Independent Read and Write Addresses

This block is a very small static store of four single-bit words. Each word sits in a level-sensitive latch, not in a flop, so it has no clock at all. A write path and a read path each have their own 2-bit address and their own active-low enable. One word can therefore be written while the same word or a different word is read.

Each path has its own 2-to-4 decoder with an active-low enable and active-low one-hot outputs. The write decoder opens one latch. While that latch is open it follows the data input. The read decoder picks which stored node reaches the output. The latches store the complement of the written bit, and the output stage inverts it back, so a read returns the bit that was written.

The write address and data are to be changed only while the write enable is inactive. Stored contents are undefined at power-up.

Top module: `latch_mem4`

## Requirements
- R1: While wrEnN is 0, the word at wrAddr (0..3) takes the value of wrData. After wrEnN returns to 1, that word keeps the value it had last.
- R2: While wrEnN is 0 and rdEnN is 0 with rdAddr equal to wrAddr, rdData equals the present wrData in the same cycle (flow-through).
- R3: While wrEnN is 1, no word changes, whatever wrData and wrAddr do.
- R4: While rdEnN is 0, rdData equals the bit most recently written to word rdAddr. The polarity is restored, so a 1 written reads back as 1.
- R5: While rdEnN is 1, rdData is 0.
- R6: A read of one word while a different word is being written returns that word's stored value, unaffected by the write.
- R7: A write to one address changes only that word. The other three words read back unchanged afterwards.
- R8: Each decoder drives at most one active-low select. With its enable at 1, it drives all selects at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrEnN | input | 1 | Write enable, active low; opens the addressed latch |
| wrAddr | input | 2 | Word to write |
| wrData | input | 1 | Bit to write |
| rdEnN | input | 1 | Read enable, active low |
| rdAddr | input | 2 | Word to read |
| rdData | output | 1 | Bit read; 0 when the read is disabled |

## Verification
The hardest case to reach from the ports is a flow-through read: both enables low on the same address, with the data changing while the latch is open. The bench sets up the address and data with the write enable high. It then lowers the write enable with the read pointed at the same word, and toggles the data while the latch is still open. It does this for every write/read address pair, so that reads of other words during a write are also covered. A reference array models the store, and every step is compared against it.

// File: rtl/latch_mem4_pkg.sv
package latch_mem4_pkg;
  localparam int ADDR_W = 2;
  localparam int WORDS  = 1 << ADDR_W;

  typedef struct packed {
    logic [WORDS-1:0] wrOpenN;  // active-low latch opens
    logic [WORDS-1:0] rdSelN;   // active-low read selects
  } memStrobes_t;
endpackage

// File: rtl/latch_mem4_dec.sv
module latch_mem4_dec #(
  parameter int ADDR_W = 2,
  localparam int OUTS = 1 << ADDR_W
) (
  input  logic              enN,
  input  logic [ADDR_W-1:0] addr,
  output logic [OUTS-1:0]   selN
);
  always_comb begin
    selN = '1;
    if (!enN) selN[addr] = 1'b0;
    AST_DEC_ONEHOT: assert ($onehot0(~selN)); // R8
    if (enN) begin
      AST_DEC_IDLE: assert (&selN); // R8
    end
  end
endmodule

// File: rtl/latch_mem4_ctrl.sv
module latch_mem4_ctrl
  import latch_mem4_pkg::*;
(
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEnN,
  input  logic [ADDR_W-1:0] rdAddr,
  output memStrobes_t       strobes
);
  logic [WORDS-1:0] wrSelN;
  logic [WORDS-1:0] rdSelN;

  latch_mem4_dec #(.ADDR_W(ADDR_W)) u_wrDec (
    .enN(wrEnN), .addr(wrAddr), .selN(wrSelN)
  );
  latch_mem4_dec #(.ADDR_W(ADDR_W)) u_rdDec (
    .enN(rdEnN), .addr(rdAddr), .selN(rdSelN)
  );

  assign strobes.wrOpenN = wrSelN;
  assign strobes.rdSelN  = rdSelN;
endmodule

// File: rtl/latch_mem4_dp.sv
module latch_mem4_dp
  import latch_mem4_pkg::*;
(
  input  memStrobes_t strobes,
  input  logic        wrData,
  output logic        rdData
);
  logic [WORDS-1:0] storeN;

  for (genvar i = 0; i < WORDS; i++) begin : g_cell
    logic cellN;
    // inverting transparent latch: open while its select is low
    always_latch begin
      if (!strobes.wrOpenN[i]) cellN <= ~wrData;
    end
    assign storeN[i] = cellN;
  end

  // only the selected cell reaches the line; the final inversion restores polarity
  always_comb begin
    logic anySel;
    logic lineN;
    anySel = ~&strobes.rdSelN;
    lineN  = |(~strobes.rdSelN & storeN);
    rdData = anySel & ~lineN;
    AST_RD_ONEHOT: assert ($onehot0(~strobes.rdSelN)); // R8
    if (&strobes.rdSelN) begin
      AST_RD_IDLE_ZERO: assert (rdData == 1'b0); // R5
    end
  end
endmodule

// File: rtl/latch_mem4.sv
module latch_mem4
  import latch_mem4_pkg::*;
(
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrData,
  input  logic              rdEnN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdData
);
  memStrobes_t strobes;

  latch_mem4_ctrl u_ctrl (
    .wrEnN(wrEnN), .wrAddr(wrAddr), .rdEnN(rdEnN), .rdAddr(rdAddr),
    .strobes(strobes)
  );

  latch_mem4_dp u_dp (
    .strobes(strobes), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/latch_mem4_bench.sv
module latch_mem4_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic wrEnN = 1'b1, wrData = 1'b0, rdEnN = 1'b1, rdData;
  logic [1:0] wrAddr = 2'd0, rdAddr = 2'd0;
  int total = 0, bad = 0;
  bit refMem [4];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latch_mem4 u_latch_mem4 (
    .wrEnN(wrEnN), .wrAddr(wrAddr), .wrData(wrData),
    .rdEnN(rdEnN), .rdAddr(rdAddr), .rdData(rdData)
  );

  // drive one step on the falling edge, compare against the model on the rising edge
  task automatic step(input logic wen, input logic [1:0] wa, input logic wd,
                      input logic ren, input logic [1:0] ra, input string tag);
    logic exp;
    @(negedge clk);
    wrEnN = wen; wrAddr = wa; wrData = wd; rdEnN = ren; rdAddr = ra;
    if (!wen) refMem[wa] = wd;
    if (ren) exp = 1'b0;
    else exp = refMem[ra];
    @(posedge clk);
    #1;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s: rdAddr=%0d actual=%b expected=%b", tag, ra, rdData, exp);
    end
  endtask

  // write with setup and release steps so address and data are stable while open
  task automatic writeWord(input logic [1:0] wa, input logic wd,
                           input logic [1:0] ra, input string tag);
    step(1'b1, wa, wd, 1'b0, ra, "R3");
    step(1'b0, wa, wd, 1'b0, ra, tag);
    step(1'b1, wa, wd, 1'b0, ra, "R1");
  endtask

  initial begin
    // fill every word before any checked read
    @(negedge clk);
    wrData = 1'b1;
    for (int a = 0; a < 4; a++) begin
      wrAddr = 2'(a); wrData = a[0] ? 1'b0 : 1'b1;
      @(negedge clk); wrEnN = 1'b0;
      @(negedge clk); wrEnN = 1'b1;
      refMem[a] = a[0] ? 1'b0 : 1'b1;
    end
    // disabled read output
    step(1'b1, 2'd0, 1'b0, 1'b1, 2'd0, "R5");
    step(1'b1, 2'd1, 1'b1, 1'b1, 2'd1, "R5");
    // read back every word with restored polarity
    for (int r = 0; r < 4; r++) step(1'b1, 2'd0, 1'b0, 1'b0, 2'(r), "R4");

    // every write/read address pair
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 4; r++) begin
        logic d;
        d = ~refMem[w];
        writeWord(2'(w), d, 2'(r), (w == r) ? "R2" : "R6");
        for (int k = 0; k < 4; k++) step(1'b1, 2'(w), d, 1'b0, 2'(k), "R7");
      end
    end

    // flow-through while data toggles inside one open window
    step(1'b1, 2'd2, 1'b0, 1'b0, 2'd2, "R3");
    step(1'b0, 2'd2, 1'b0, 1'b0, 2'd2, "R2");
    step(1'b0, 2'd2, 1'b1, 1'b0, 2'd2, "R2");
    step(1'b0, 2'd2, 1'b0, 1'b0, 2'd2, "R2");
    step(1'b0, 2'd2, 1'b1, 1'b0, 2'd2, "R2");
    step(1'b1, 2'd2, 1'b1, 1'b0, 2'd2, "R1");
    // write with the read disabled still updates storage, output stays 0
    step(1'b1, 2'd3, 1'b0, 1'b1, 2'd3, "R5");
    step(1'b0, 2'd3, 1'b0, 1'b1, 2'd3, "R5");
    step(1'b1, 2'd3, 1'b0, 1'b0, 2'd3, "R1");

    // hold: wiggle address and data with the write disabled
    for (int n = 0; n < 16; n++) begin
      step(1'b1, 2'(n), n[2], 1'b0, 2'(n >> 2), "R3");
      step(1'b1, 2'(n + 1), ~n[2], 1'b1, 2'(n), "R5");
    end
    for (int k = 0; k < 4; k++) step(1'b1, 2'd0, 1'b1, 1'b0, 2'(k), "R3");
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule